// File: doc/BRIEF.md
# Dual-Interval Waveform Timer

This block is an 8-bit prescaler feeding an 8-bit down-counter. The count ticks come from one of two periodic strobes, a fast one (one pulse every 2 clocks) and a slow one (one pulse every 16 clocks). Software programs the block through a byte-wide write port and can read state back through a combinational read port. The block has two modes.

In timer mode the counter reloads from the primary latch each time it underflows, and each underflow raises a one-clock interrupt pulse. In waveform mode the counter runs the primary value and the secondary value in turn. The output pin flips at every underflow, so the two latches set the high time and the low time separately.

When the prescaler value is 0, either interval can be made half a count tick longer. The secondary value and the two extension bits are held in staging registers. A write to the primary latch moves all of them forward together, and they take effect when the next primary interval begins.

Top module: `wave_timer`

## Requirements
- R1: After reset, wave_o and irq_o are 0, the control register (address 0) reads 0x00, and the count (address 2) reads 0xFF.
- R2: In timer mode (control bit 0 = 0), an underflow occurs every (p+1)*(n+1) count ticks, where p is the prescaler value (address 1) and n is the primary value (address 2). Each underflow gives a one-clock pulse on irq_o.
- R3: Control bit 1 selects the count tick: 0 selects the fast strobe and 1 selects the slow strobe.
- R4: While control bit 2 (stop) is 1, the count read at address 2 does not change and irq_o stays 0.
- R5: A primary write made while stopped loads the counter, and the count reads back the written value on the next cycle.
- R6: In timer mode while running, a primary write loads both the latch and the counter when control bit 3 is 0. When bit 3 is 1 it loads only the latch, and the new value is used from the next underflow on.
- R7: In waveform mode (control bit 0 = 1), the primary interval lasts (p+1)*(n+1) ticks, the secondary interval lasts (p+1)*(m+1) ticks, and wave_o flips at each underflow. m is the secondary value (address 3).
- R8: Control bit 4 sets the polarity. With 0, the stopped level is low, the primary interval is high and the secondary interval is low. With 1, all three are inverted.
- R9: With p = 0, control bit 5 adds half a tick to the primary interval and control bit 6 adds half a tick to the secondary interval.
- R10: With p not 0, control bits 5 and 6 have no effect on either interval.
- R11: Writes to address 3 and to control bits 5 and 6 take effect only after a primary write, and only from the start of the following primary interval.
- R12: Address 3 reads as 0. Address 2 returns the current count in both intervals, so it reads m on the first cycle of a secondary interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 prescaler, 2 primary, 3 secondary |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address: 0 control, 1 prescaler count, 2 count, 3 reads 0 |
| rd_data_o | output | 8 | Read data, combinational |
| fast_stb_i | input | 1 | Fast count strobe, one pulse every 2 clocks |
| slow_stb_i | input | 1 | Slow count strobe, one pulse every 16 clocks |
| wave_o | output | 1 | Waveform output |
| irq_o | output | 1 | Underflow pulse |

## Verification
Any fault in the half-step phase counter or in the prescaler shows up as a waveform interval or interrupt period that is off by one clock or more. It appears within the first full period after configuration, which the bench measures edge to edge in clock cycles. A staging fault, where values are committed early or late, changes the length of the first primary or secondary interval after a primary write. The count readback shows a load fault or a stop fault on the very next cycle.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic {MODE_TIMER = 1'b0, MODE_WAVE = 1'b1} mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PRE  = 2'd1;
  localparam logic [1:0] ADDR_PRI  = 2'd2;
  localparam logic [1:0] ADDR_SEC  = 2'd3;

  localparam int CB_MODE  = 0;
  localparam int CB_SRC   = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_LONLY = 3;
  localparam int CB_LEVEL = 4;
  localparam int CB_EXTP  = 5;
  localparam int CB_EXTS  = 6;
endpackage

// File: rtl/wt_tick_gen.sv
module wt_tick_gen #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic fast_stb_i,
  input  logic slow_stb_i,
  output logic full_o,
  output logic half_o
);
  localparam int CW = $clog2(SLOW_DIV) + 1;
  localparam logic [CW-1:0] MID_FAST = CW'(FAST_DIV / 2);
  localparam logic [CW-1:0] MID_SLOW = CW'(SLOW_DIV / 2);

  logic [CW-1:0] since_q;
  logic          mid;

  assign full_o = src_i ? slow_stb_i : fast_stb_i;
  // mid-point half tick, half a source period after the last full tick
  assign mid    = !full_o && (since_q == (src_i ? MID_SLOW : MID_FAST));
  assign half_o = full_o | mid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_q <= '0;
    else if (full_o)            since_q <= CW'(1);
    else if (since_q != '1)     since_q <= since_q + CW'(1);
  end

  generate
    if (SLOW_DIV > 2) begin : g_slow_chk
      assert_slow_mid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && src_i) |=> (full_o || !half_o));
    end
  endgenerate
endmodule

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  output logic         pulse_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  assign pulse_o = run_i && tick_i && !load_i && (cnt_q == '0);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (pulse_o)          cnt_q <= reload_i;
    else if (run_i && tick_i)  cnt_q <= cnt_q - W'(1);
  end

  assert_pre_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/wt_core.sv
module wt_core
  import wt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  mode_e        mode_i,
  input  logic         half_mode_i,
  input  logic         step_i,
  input  logic         pri_wr_i,
  input  logic [W-1:0] pri_val_i,
  input  logic         latch_only_i,
  input  logic [W-1:0] sec_stg_i,
  input  logic         extp_stg_i,
  input  logic         exts_stg_i,
  input  logic         level_i,
  output logic         wave_o,
  output logic         irq_o,
  output logic [W-1:0] cnt_o
);
  localparam logic PH_PRI = 1'b0;
  localparam logic PH_SEC = 1'b1;

  logic [W-1:0] cnt_q, pri_q, sec_pend_q, sec_act_q;
  logic [1:0]   sub_q;
  logic         phase_q, pend_q, irq_q;
  logic         extp_pend_q, exts_pend_q, extp_act_q, exts_act_q;
  logic         wave_m, uf, extp_next;

  // half-step preload: 1 nominal, 2 when the interval is extended
  function automatic logic [1:0] sub_load(input logic h, input logic e);
    return h ? (e ? 2'd2 : 2'd1) : 2'd0;
  endfunction

  assign wave_m    = (mode_i == MODE_WAVE);
  assign uf        = run_i && step_i && !pri_wr_i && (cnt_q == '0) &&
                     (!half_mode_i || sub_q == 2'd0);
  assign extp_next = pend_q ? extp_pend_q : extp_act_q;
  assign wave_o    = level_i ^ (wave_m && run_i && phase_q == PH_PRI);
  assign irq_o     = irq_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1; pri_q <= '1; sec_pend_q <= '1; sec_act_q <= '1;
      sub_q <= 2'd1; phase_q <= PH_PRI; pend_q <= 1'b0; irq_q <= 1'b0;
      extp_pend_q <= 1'b0; exts_pend_q <= 1'b0;
      extp_act_q  <= 1'b0; exts_act_q  <= 1'b0;
    end else begin
      irq_q <= uf;
      if (pri_wr_i) begin
        pri_q       <= pri_val_i;
        sec_pend_q  <= sec_stg_i;
        extp_pend_q <= extp_stg_i;
        exts_pend_q <= exts_stg_i;
        pend_q      <= 1'b1;
        if (!run_i) begin
          cnt_q      <= pri_val_i;
          phase_q    <= PH_PRI;
          sec_act_q  <= sec_stg_i;
          extp_act_q <= extp_stg_i;
          exts_act_q <= exts_stg_i;
          pend_q     <= 1'b0;
          sub_q      <= sub_load(half_mode_i, wave_m && extp_stg_i);
        end else if (!wave_m && !latch_only_i) begin
          cnt_q <= pri_val_i;
          sub_q <= sub_load(half_mode_i, 1'b0);
        end
      end else if (uf) begin
        if (!wave_m) begin
          cnt_q <= pri_q;
          sub_q <= sub_load(half_mode_i, 1'b0);
        end else if (phase_q == PH_PRI) begin
          cnt_q   <= sec_act_q;
          sub_q   <= sub_load(half_mode_i, exts_act_q);
          phase_q <= PH_SEC;
        end else begin
          cnt_q   <= pri_q;
          sub_q   <= sub_load(half_mode_i, extp_next);
          phase_q <= PH_PRI;
          if (pend_q) begin
            sec_act_q  <= sec_pend_q;
            extp_act_q <= extp_pend_q;
            exts_act_q <= exts_pend_q;
            pend_q     <= 1'b0;
          end
        end
      end else if (run_i && step_i) begin
        if (half_mode_i && sub_q != 2'd0) begin
          sub_q <= sub_q - 2'd1;
        end else begin
          cnt_q <= cnt_q - W'(1);
          sub_q <= sub_load(half_mode_i, 1'b0);
        end
      end
    end
  end

  assert_stop_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !pri_wr_i) |=> $stable(cnt_q));

  assert_wave_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(uf && wave_m) && run_i && wave_m && level_i == $past(level_i))
      |-> (wave_o != $past(wave_o)));

  assert_stopped_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_wr_i && !run_i) |=> (cnt_q == $past(pri_val_i)));
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wt_pkg::*;
#(
  parameter int W        = 8,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  input  logic         fast_stb_i,
  input  logic         slow_stb_i,
  output logic         wave_o,
  output logic         irq_o
);
  mode_e        mode_q;
  logic         src_q, stop_q, lonly_q, level_q, extp_stg_q, exts_stg_q;
  logic [W-1:0] pre_lat_q, sec_stg_q, pre_cnt, cnt;
  logic         ctrl_wr, pre_wr, pri_wr, sec_wr;
  logic         run, half_mode, full_tick, half_tick, pre_pulse, step;
  logic [W-1:0] ctrl_rd;

  assign ctrl_wr   = wr_en_i && wr_addr_i == ADDR_CTRL;
  assign pre_wr    = wr_en_i && wr_addr_i == ADDR_PRE;
  assign pri_wr    = wr_en_i && wr_addr_i == ADDR_PRI;
  assign sec_wr    = wr_en_i && wr_addr_i == ADDR_SEC;
  assign run       = !stop_q;
  assign half_mode = (pre_lat_q == '0);
  assign step      = half_mode ? half_tick : pre_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_TIMER; src_q <= 1'b0; stop_q <= 1'b0; lonly_q <= 1'b0;
      level_q <= 1'b0; extp_stg_q <= 1'b0; exts_stg_q <= 1'b0;
      pre_lat_q <= '0; sec_stg_q <= '1;
    end else begin
      if (ctrl_wr) begin
        mode_q     <= mode_e'(wr_data_i[CB_MODE]);
        src_q      <= wr_data_i[CB_SRC];
        stop_q     <= wr_data_i[CB_STOP];
        lonly_q    <= wr_data_i[CB_LONLY];
        level_q    <= wr_data_i[CB_LEVEL];
        extp_stg_q <= wr_data_i[CB_EXTP];
        exts_stg_q <= wr_data_i[CB_EXTS];
      end
      if (pre_wr) pre_lat_q <= wr_data_i;
      if (sec_wr) sec_stg_q <= wr_data_i;
    end
  end

  wt_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk_i, .rst_ni, .src_i(src_q), .fast_stb_i, .slow_stb_i,
    .full_o(full_tick), .half_o(half_tick)
  );

  wt_prescaler #(.W(W)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .tick_i(full_tick), .load_i(pre_wr),
    .load_val_i(wr_data_i), .reload_i(pre_lat_q), .pulse_o(pre_pulse), .cnt_o(pre_cnt)
  );

  wt_core #(.W(W)) u_core (
    .clk_i, .rst_ni, .run_i(run), .mode_i(mode_q), .half_mode_i(half_mode),
    .step_i(step), .pri_wr_i(pri_wr), .pri_val_i(wr_data_i), .latch_only_i(lonly_q),
    .sec_stg_i(sec_stg_q), .extp_stg_i(extp_stg_q), .exts_stg_i(exts_stg_q),
    .level_i(level_q), .wave_o, .irq_o, .cnt_o(cnt)
  );

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[CB_MODE]  = mode_q;
    ctrl_rd[CB_SRC]   = src_q;
    ctrl_rd[CB_STOP]  = stop_q;
    ctrl_rd[CB_LONLY] = lonly_q;
    ctrl_rd[CB_LEVEL] = level_q;
    ctrl_rd[CB_EXTP]  = extp_stg_q;
    ctrl_rd[CB_EXTS]  = exts_stg_q;
    case (rd_addr_i)
      ADDR_CTRL: rd_data_o = ctrl_rd;
      ADDR_PRE:  rd_data_o = pre_cnt;
      ADDR_PRI:  rd_data_o = cnt;
      default:   rd_data_o = '0;
    endcase
  end

  assert_irq_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_stop_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stop_q) && stop_q) |-> !irq_o);
endmodule

// File: tb/tb_wave_timer.sv
module tb_wave_timer;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 6000;

  logic       clk, rst_n, wr_en, fast_stb, slow_stb, wave, irq;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  int         checks = 0, failures = 0, cyc = 0;
  bit         done = 0;

  wave_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .fast_stb_i(fast_stb), .slow_stb_i(slow_stb), .wave_o(wave), .irq_o(irq)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc      <= cyc + 1;
    fast_stb <= (cyc % 2) == 0;
    slow_stb <= (cyc % 16) == 0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrl(input bit mode, input bit src, input bit stop,
                                      input bit lonly, input bit lvl, input bit ep, input bit es);
    return {1'b0, es, ep, lvl, lonly, stop, src, mode};
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1 v = int'(rd_data);
  endtask

  task automatic measure_irq(output int per);
    int n = 0;
    per = -1;
    while (n < LIMIT && !irq) begin @(negedge clk); n++; end
    if (n >= LIMIT) return;
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < LIMIT);
    if (n < LIMIT) per = n;
  endtask

  // first = time at pol, second = time at !pol
  task automatic measure_wave(input bit pol, output int first, output int second);
    int n = 0; logic prev;
    first = -1; second = -1;
    prev = wave;
    @(negedge clk);
    while (n < LIMIT && !(prev != pol && wave == pol)) begin prev = wave; @(negedge clk); n++; end
    if (n >= LIMIT) return;
    n = 0;
    while (wave == pol && n < LIMIT) begin @(negedge clk); n++; end
    first = n; n = 0;
    while (wave != pol && n < LIMIT) begin @(negedge clk); n++; end
    second = n;
  endtask

  task automatic setup_timer(input int p, input int n, input bit src);
    bus_wr(0, ctrl(0, src, 1, 0, 0, 0, 0));
    bus_wr(1, 8'(p));
    bus_wr(2, 8'(n));
    bus_wr(0, ctrl(0, src, 0, 0, 0, 0, 0));
  endtask

  task automatic setup_wave(input int p, input int n, input int m, input bit src,
                            input bit lvl, input bit ep, input bit es);
    bus_wr(0, ctrl(1, src, 1, 0, lvl, ep, es));
    bus_wr(1, 8'(p));
    bus_wr(3, 8'(m));
    bus_wr(2, 8'(n));
    bus_wr(0, ctrl(1, src, 0, 0, lvl, ep, es));
  endtask

  function automatic int ivl(input int p, input int n, input bit src, input bit ext);
    int d = src ? 16 : 2;
    return d * (p + 1) * (n + 1) + ((p == 0 && ext) ? d / 2 : 0);
  endfunction

  task automatic wave_case(input string req, input int p, input int n, input int m,
                           input bit src, input bit lvl, input bit ep, input bit es);
    int a, b;
    setup_wave(p, n, m, src, lvl, ep, es);
    measure_wave(!lvl, a, b);
    chk({req, " primary"}, a, ivl(p, n, src, ep));
    chk({req, " secondary"}, b, ivl(p, m, src, es));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, v2, per, a, b, seen;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 wave", int'(wave), 0);
    chk("R1 irq", int'(irq), 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R1 count", v, 255);

    // R2 timer period sweep on fast source
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 3; k++) begin
        int n = (k == 0) ? 0 : (k == 1 ? 3 : 7);
        setup_timer(p, n, 0);
        measure_irq(per);
        chk($sformatf("R2 timer p=%0d n=%0d", p, n), per, ivl(p, n, 0, 0));
      end
    // R3 slow source
    setup_timer(1, 2, 1);
    measure_irq(per); chk("R3 slow p=1 n=2", per, ivl(1, 2, 1, 0));
    setup_timer(0, 3, 1);
    measure_irq(per); chk("R3 slow p=0 n=3", per, ivl(0, 3, 1, 0));

    // R4 stop holds count, no irq
    setup_timer(0, 100, 0);
    repeat (20) @(negedge clk);
    bus_wr(0, ctrl(0, 0, 1, 0, 0, 0, 0));
    rd(2, v); seen = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (irq) seen++; end
    rd(2, v2);
    chk("R4 count stable", v2, v);
    chk("R4 no irq", seen, 0);
    // R5 stopped primary write loads counter
    bus_wr(2, 8'h2A);
    rd(2, v); chk("R5 load", v, 42);

    // R6 running reload vs latch only
    setup_timer(0, 200, 0);
    repeat (10) @(negedge clk);
    bus_wr(2, 8'h50);
    rd(2, v); chk("R6 immediate load", v, 80);
    bus_wr(0, ctrl(0, 0, 0, 1, 0, 0, 0));
    bus_wr(2, 8'd5);
    rd(2, v); chk("R6 latch only keeps count", int'(v > 10), 1);
    measure_irq(per); chk("R6 new latch after underflow", per, ivl(0, 5, 0, 0));

    // R7 waveform sweep, R8 polarity
    wave_case("R7 p0 n1 m3", 0, 1, 3, 0, 0, 0, 0);
    wave_case("R7 p0 n4 m0", 0, 4, 0, 0, 0, 0, 0);
    wave_case("R7 p2 n2 m2", 2, 2, 2, 0, 0, 0, 0);
    wave_case("R7 p2 n1 m3 slow", 2, 1, 3, 1, 0, 0, 0);
    wave_case("R8 level1 n1 m3", 0, 1, 3, 0, 1, 0, 0);
    bus_wr(0, ctrl(1, 0, 1, 0, 1, 0, 0));
    chk("R8 idle level1", int'(wave), 1);
    bus_wr(0, ctrl(1, 0, 1, 0, 0, 0, 0));
    chk("R8 idle level0", int'(wave), 0);

    // R9 half-tick extensions
    wave_case("R9 ext primary", 0, 3, 2, 0, 0, 1, 0);
    wave_case("R9 ext secondary", 0, 3, 2, 0, 0, 0, 1);
    wave_case("R9 ext both slow", 0, 1, 1, 1, 0, 1, 1);
    wave_case("R9 ext both level1", 0, 2, 4, 0, 1, 1, 1);
    // R10 ignored with nonzero prescaler
    wave_case("R10 ext ignored", 1, 2, 3, 0, 0, 1, 1);

    // R11 staging
    setup_wave(0, 3, 3, 0, 0, 0, 0);
    bus_wr(3, 8'd7);
    bus_wr(0, ctrl(1, 0, 0, 0, 0, 1, 0));
    measure_wave(1, a, b);
    chk("R11 staged primary unchanged", a, ivl(0, 3, 0, 0));
    chk("R11 staged secondary unchanged", b, ivl(0, 3, 0, 0));
    bus_wr(2, 8'd3);
    measure_wave(1, a, b);
    chk("R11 committed primary", a, ivl(0, 3, 0, 1));
    chk("R11 committed secondary", b, ivl(0, 7, 0, 0));

    // R12 readback
    setup_wave(0, 3, 9, 0, 0, 0, 0);
    rd(3, v); chk("R12 secondary reads zero", v, 0);
    begin
      logic prev; int n = 0;
      rd_addr = 2;
      prev = wave; @(negedge clk);
      while (n < LIMIT && !(prev == 1 && wave == 0)) begin prev = wave; @(negedge clk); n++; end
      #1 chk("R12 count in secondary", int'(rd_data), 9);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule